// File: doc/BRIEF.md
# Threshold-Request Byte FIFO

This block is a byte-wide FIFO that sits between a host-facing data port and a serial shift engine on a two-wire display data channel. A direction select decides who fills it and who drains it. In receive direction the engine pushes bytes through a valid/ready handshake and the host pops them. In transmit direction the host pushes bytes and the engine pops them through a second valid/ready handshake.

The FIFO raises a service-request flag from its fill level. In receive direction the flag means enough bytes are waiting to be read. In transmit direction it means enough room has opened up to be refilled. The compare against each programmable threshold can be strict or inclusive. A self-clearing flush empties the store. Three sticky error flags record overflow, underflow and accesses that do not match the selected direction. Each flag stays set until its write-1-to-clear bit is pulsed, and these flags feed the surrounding status register.

Top module: `ddc_byte_fifo`

## Requirements
- R1: After reset, `fifo_level` is 0, `flush_busy` is 0 and all three error flags are 0.
- R2: Bytes leave the FIFO in the order they entered it, and up to DEPTH (default 16) bytes are held.
- R3: With `dir_rx`=1, `fifo_req` is 1 when `fifo_level` > `rx_thresh` and `incl_mode`=0, or when `fifo_level` >= `rx_thresh` and `incl_mode`=1.
- R4: With `dir_rx`=0, `fifo_req` is 1 when `fifo_level` < `tx_thresh` and `incl_mode`=0, or when `fifo_level` <= `tx_thresh` and `incl_mode`=1. Threshold 1 (strict) and threshold 0 (inclusive) therefore both request only when the FIFO is empty.
- R5: A one-cycle pulse on `flush_wr` makes `flush_busy` read 1 after the next clock edge. After the edge that follows, `fifo_level` is 0 and `flush_busy` is 0. Host accesses made while `flush_busy` is 1 are ignored and set no flag.
- R6: With `dir_rx`=1 the host pops bytes and the engine pushes them, and `eng_pop_valid` stays 0. With `dir_rx`=0 the host pushes bytes and the engine pops them, and `eng_push_ready` stays 0.
- R7: A host pop with `dir_rx`=1 while the FIFO is empty sets `err_underflow` and leaves the level at 0.
- R8: A host push with `dir_rx`=0 while the FIFO is full sets `err_overflow`. The byte is dropped and the stored contents are unchanged.
- R9: A host push while `dir_rx`=1, or a host pop while `dir_rx`=0, sets `err_illegal` and does not change the FIFO contents.
- R10: The error flags are sticky and a flush does not clear them. `flag_clr` bit 0 clears `err_overflow`, bit 1 clears `err_underflow` and bit 2 clears `err_illegal`. A new error event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_rx | input | 1 | 1: receive (engine fills, host drains); 0: transmit |
| incl_mode | input | 1 | 1: threshold compares are inclusive |
| rx_thresh | input | AW (4) | Receive threshold, 0 to DEPTH-1 |
| tx_thresh | input | AW (4) | Transmit threshold, 0 to DEPTH-1 |
| flush_wr | input | 1 | Host write of 1 to the flush field |
| flush_busy | output | 1 | Flush field read-back, 1 while a flush is pending |
| flag_clr | input | 3 | Write-1-to-clear for the error flags |
| host_wr_en | input | 1 | Host byte push strobe |
| host_wr_data | input | DW (8) | Host push data |
| host_rd_en | input | 1 | Host byte pop strobe |
| host_rd_data | output | DW (8) | Byte at the head of the FIFO |
| eng_push_valid | input | 1 | Engine offers a received byte |
| eng_push_data | input | DW (8) | Engine received byte |
| eng_push_ready | output | 1 | FIFO accepts an engine byte |
| eng_pop_valid | output | 1 | FIFO offers a byte to transmit |
| eng_pop_data | output | DW (8) | Byte offered to the engine |
| eng_pop_ready | input | 1 | Engine takes the offered byte |
| fifo_level | output | LW (5) | Number of stored bytes |
| fifo_req | output | 1 | Service request |
| err_overflow | output | 1 | Sticky transmit overflow flag |
| err_underflow | output | 1 | Sticky receive underflow flag |
| err_illegal | output | 1 | Sticky wrong-direction access flag |

## Verification
A corrupted pointer or count shows up within the same access as a wrong byte at `host_rd_data` or `eng_pop_data`, or as a `fifo_level` that breaks the count of pushes minus pops. The request flag is combinational on the stored level, so a bad threshold compare is visible in the very cycle the level reaches the boundary. The bench fills the FIFO to levels on each side of every compare. A stuck flush, or a flag that drops early, is visible two edges after the flush pulse or one edge after the clear.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } fifo_dir_e;

  localparam int FLAG_OVF = 0;
  localparam int FLAG_UNF = 1;
  localparam int FLAG_ILL = 2;
  localparam int NFLAGS   = 3;

  // Request rule: receive compares fullness, transmit compares emptiness.
  function automatic logic calc_request(fifo_dir_e dir, logic incl,
                                        int unsigned level,
                                        int unsigned rx_th,
                                        int unsigned tx_th);
    logic r;
    if (dir == DIR_RX) r = incl ? (level >= rx_th) : (level > rx_th);
    else               r = incl ? (level <= tx_th) : (level < tx_th);
    return r;
  endfunction

endpackage

// File: rtl/bfifo_store.sv
module bfifo_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] push_data,
  output logic [DW-1:0] head_data,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full      = (level == LW'(DEPTH));
  assign empty     = (level == '0);
  assign head_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else if (clear) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= ptr_inc(wptr);
      if (pop)  rptr <= ptr_inc(rptr);
      case ({push, pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)); // R2

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !clear) |=> full); // R8

endmodule

// File: rtl/bfifo_reqgen.sv
module bfifo_reqgen
  import bfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  fifo_dir_e     dir,
  input  logic          incl,
  input  logic [LW-1:0] level,
  input  logic [AW-1:0] rx_th,
  input  logic [AW-1:0] tx_th,
  output logic          req
);

  always_comb begin
    req = calc_request(dir, incl, 32'(level), 32'(rx_th), 32'(tx_th));
  end

endmodule

// File: rtl/bfifo_errflags.sv
module bfifo_errflags
  import bfifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAGS-1:0] ev,
  input  logic [NFLAGS-1:0] clr,
  output logic [NFLAGS-1:0] flags
);

  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[g] <= 1'b0;
      else if (ev[g])  flags[g] <= 1'b1;
      else if (clr[g]) flags[g] <= 1'b0;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[g] && !clr[g]) |=> flags[g]); // R10
  end

endmodule

// File: rtl/ddc_byte_fifo.sv
module ddc_byte_fifo
  import bfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_rx,
  input  logic          incl_mode,
  input  logic [AW-1:0] rx_thresh,
  input  logic [AW-1:0] tx_thresh,
  input  logic          flush_wr,
  output logic          flush_busy,
  input  logic [2:0]    flag_clr,
  input  logic          host_wr_en,
  input  logic [DW-1:0] host_wr_data,
  input  logic          host_rd_en,
  output logic [DW-1:0] host_rd_data,
  input  logic          eng_push_valid,
  input  logic [DW-1:0] eng_push_data,
  output logic          eng_push_ready,
  output logic          eng_pop_valid,
  output logic [DW-1:0] eng_pop_data,
  input  logic          eng_pop_ready,
  output logic [LW-1:0] fifo_level,
  output logic          fifo_req,
  output logic          err_overflow,
  output logic          err_underflow,
  output logic          err_illegal
);

  fifo_dir_e         dir;
  logic              full, empty;
  logic              push, pop;
  logic [DW-1:0]     push_data, head;
  logic              host_push_ok, host_pop_ok;
  logic              eng_push_fire, eng_pop_fire;
  logic              ev_overflow, ev_underflow, ev_illegal;
  logic [NFLAGS-1:0] ev_vec, flag_vec;
  logic              live;

  assign dir  = fifo_dir_e'(dir_rx);
  assign live = !flush_busy;

  // Flush: one pending cycle, then the store is cleared.
  always_ff @(posedge clk) begin
    if (!rst_n) flush_busy <= 1'b0;
    else        flush_busy <= flush_wr && !flush_busy;
  end

  // Engine handshakes follow the selected direction.
  assign eng_push_ready = live && (dir == DIR_RX) && !full;
  assign eng_pop_valid  = live && (dir == DIR_TX) && !empty;
  assign eng_push_fire  = eng_push_valid && eng_push_ready;
  assign eng_pop_fire   = eng_pop_ready && eng_pop_valid;

  assign host_push_ok = live && host_wr_en && (dir == DIR_TX) && !full;
  assign host_pop_ok  = live && host_rd_en && (dir == DIR_RX) && !empty;

  assign push      = host_push_ok || eng_push_fire;
  assign pop       = host_pop_ok  || eng_pop_fire;
  assign push_data = (dir == DIR_RX) ? eng_push_data : host_wr_data;

  // Error events seen at the host port.
  assign ev_overflow  = live && host_wr_en && (dir == DIR_TX) && full;
  assign ev_underflow = live && host_rd_en && (dir == DIR_RX) && empty;
  assign ev_illegal   = live && ((host_wr_en && (dir == DIR_RX)) ||
                                 (host_rd_en && (dir == DIR_TX)));

  always_comb begin
    ev_vec           = '0;
    ev_vec[FLAG_OVF] = ev_overflow;
    ev_vec[FLAG_UNF] = ev_underflow;
    ev_vec[FLAG_ILL] = ev_illegal;
  end

  bfifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (flush_busy),
    .push      (push),
    .pop       (pop),
    .push_data (push_data),
    .head_data (head),
    .level     (fifo_level),
    .full      (full),
    .empty     (empty)
  );

  bfifo_reqgen #(.DEPTH(DEPTH)) u_req (
    .dir   (dir),
    .incl  (incl_mode),
    .level (fifo_level),
    .rx_th (rx_thresh),
    .tx_th (tx_thresh),
    .req   (fifo_req)
  );

  bfifo_errflags u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (ev_vec),
    .clr   (flag_clr),
    .flags (flag_vec)
  );

  assign err_overflow  = flag_vec[FLAG_OVF];
  assign err_underflow = flag_vec[FLAG_UNF];
  assign err_illegal   = flag_vec[FLAG_ILL];
  assign host_rd_data  = head;
  assign eng_pop_data  = head;

  AST_FLUSH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |=> (fifo_level == '0 && !flush_busy)); // R5

  AST_UNDERFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_underflow |=> (err_underflow && fifo_level == '0)); // R7

  AST_ILLEGAL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_illegal |=> err_illegal); // R9

  AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_push_ready && eng_pop_valid)); // R6

endmodule

// File: tb/test_ddc_byte_fifo.sv
`timescale 1ns/1ps
module test_ddc_byte_fifo;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dir_rx, incl_mode, flush_wr, flush_busy;
  logic [3:0] rx_thresh, tx_thresh;
  logic [2:0] flag_clr;
  logic       host_wr_en, host_rd_en;
  logic [7:0] host_wr_data, host_rd_data;
  logic       eng_push_valid, eng_push_ready, eng_pop_valid, eng_pop_ready;
  logic [7:0] eng_push_data, eng_pop_data;
  logic [4:0] fifo_level;
  logic       fifo_req, err_overflow, err_underflow, err_illegal;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  ddc_byte_fifo #(.DEPTH(DEPTH), .DW(8)) i_ddc_byte_fifo (
    .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx), .incl_mode(incl_mode),
    .rx_thresh(rx_thresh), .tx_thresh(tx_thresh), .flush_wr(flush_wr),
    .flush_busy(flush_busy), .flag_clr(flag_clr), .host_wr_en(host_wr_en),
    .host_wr_data(host_wr_data), .host_rd_en(host_rd_en),
    .host_rd_data(host_rd_data), .eng_push_valid(eng_push_valid),
    .eng_push_data(eng_push_data), .eng_push_ready(eng_push_ready),
    .eng_pop_valid(eng_pop_valid), .eng_pop_data(eng_pop_data),
    .eng_pop_ready(eng_pop_ready), .fifo_level(fifo_level),
    .fifo_req(fifo_req), .err_overflow(err_overflow),
    .err_underflow(err_underflow), .err_illegal(err_illegal)
  );

  // {dir_rx, incl, threshold[4:0], level[4:0], expected request}
  localparam int NV = 11;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 1'b0, 5'd3,  5'd3,  1'b0},
    {1'b1, 1'b0, 5'd3,  5'd4,  1'b1},
    {1'b1, 1'b1, 5'd3,  5'd3,  1'b1},
    {1'b1, 1'b1, 5'd3,  5'd2,  1'b0},
    {1'b1, 1'b0, 5'd15, 5'd16, 1'b1},
    {1'b0, 1'b0, 5'd1,  5'd0,  1'b1},
    {1'b0, 1'b0, 5'd1,  5'd1,  1'b0},
    {1'b0, 1'b1, 5'd0,  5'd0,  1'b1},
    {1'b0, 1'b1, 5'd0,  5'd1,  1'b0},
    {1'b0, 1'b1, 5'd5,  5'd5,  1'b1},
    {1'b0, 1'b0, 5'd5,  5'd5,  1'b0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic host_push(logic [7:0] b);
    host_wr_en = 1'b1; host_wr_data = b;
    tick();
    host_wr_en = 1'b0;
  endtask

  task automatic host_pop(output logic [7:0] b);
    b = host_rd_data;
    host_rd_en = 1'b1;
    tick();
    host_rd_en = 1'b0;
  endtask

  task automatic eng_push(logic [7:0] b);
    eng_push_valid = 1'b1; eng_push_data = b;
    tick();
    eng_push_valid = 1'b0;
  endtask

  task automatic eng_pop(output logic [7:0] b);
    b = eng_pop_data;
    eng_pop_ready = 1'b1;
    tick();
    eng_pop_ready = 1'b0;
  endtask

  task automatic do_flush();
    flush_wr = 1'b1;
    tick();
    flush_wr = 1'b0;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    rst_n = 1'b0; dir_rx = 1'b0; incl_mode = 1'b0;
    rx_thresh = 4'd0; tx_thresh = 4'd1; flush_wr = 1'b0; flag_clr = 3'b0;
    host_wr_en = 1'b0; host_wr_data = 8'h0; host_rd_en = 1'b0;
    eng_push_valid = 1'b0; eng_push_data = 8'h0; eng_pop_ready = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    check("R1 level", fifo_level, 0);
    check("R1 busy", flush_busy, 0);
    check("R1 flags", {err_overflow, err_underflow, err_illegal}, 0);

    // R6 transmit direction: engine cannot push
    check("R6 push_ready tx", eng_push_ready, 0);

    // R2/R8 fill to full, overflow, then drain in order
    for (int i = 0; i < DEPTH; i++) host_push(8'h10 + 8'(i));
    check("R2 full level", fifo_level, DEPTH);
    host_push(8'h99);
    check("R8 overflow flag", err_overflow, 1);
    check("R8 level kept", fifo_level, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      eng_pop(b);
      check("R2 tx order", b, 8'h10 + 8'(i));
    end
    check("R2 drained", fifo_level, 0);

    // R6 receive direction: engine fills, host drains
    dir_rx = 1'b1;
    #1;
    check("R6 pop_valid rx", eng_pop_valid, 0);
    check("R6 push_ready rx", eng_push_ready, 1);
    eng_push(8'h31); eng_push(8'h32); eng_push(8'h33);
    check("R6 pop_valid rx filled", eng_pop_valid, 0);
    for (int i = 0; i < 3; i++) begin
      host_pop(b);
      check("R2 rx order", b, 8'h31 + 8'(i));
    end

    // R7 underflow
    host_pop(b);
    check("R7 underflow flag", err_underflow, 1);
    check("R7 level", fifo_level, 0);

    // R9 illegal: host push in receive direction
    eng_push(8'h44);
    host_push(8'h77);
    check("R9 illegal flag", err_illegal, 1);
    check("R9 level", fifo_level, 1);
    host_pop(b);
    check("R9 contents", b, 8'h44);

    // R10 sticky through flush, selective clear
    do_flush();
    check("R10 flags after flush", {err_overflow, err_underflow, err_illegal}, 3'b111);
    flag_clr = 3'b001; tick(); flag_clr = 3'b000;
    check("R10 clear ovf", {err_overflow, err_underflow, err_illegal}, 3'b011);
    flag_clr = 3'b010; host_rd_en = 1'b1; tick();
    host_rd_en = 1'b0; flag_clr = 3'b000;
    check("R10 set beats clear", err_underflow, 1);
    flag_clr = 3'b111; tick(); flag_clr = 3'b000;
    check("R10 clear all", {err_overflow, err_underflow, err_illegal}, 0);

    // R5 flush timing and ignored host access while busy
    dir_rx = 1'b0;
    host_push(8'hA0); host_push(8'hA1);
    flush_wr = 1'b1; tick(); flush_wr = 1'b0;
    check("R5 busy", flush_busy, 1);
    host_wr_en = 1'b1; host_wr_data = 8'hEE; host_rd_en = 1'b1;
    tick();
    host_wr_en = 1'b0; host_rd_en = 1'b0;
    check("R5 busy done", flush_busy, 0);
    check("R5 level zero", fifo_level, 0);
    check("R5 no flags", {err_overflow, err_underflow, err_illegal}, 0);

    // R3/R4 request compare table
    for (int v = 0; v < NV; v++) begin
      logic       vrx, vinc, vexp;
      logic [4:0] vth, vlv;
      {vrx, vinc, vth, vlv, vexp} = VEC[v];
      dir_rx = vrx;
      do_flush();
      for (int k = 0; k < int'(vlv); k++) begin
        if (vrx) eng_push(8'(k)); else host_push(8'(k));
      end
      incl_mode = vinc; rx_thresh = vth[3:0]; tx_thresh = vth[3:0];
      #1;
      check(vrx ? "R3 rx request" : "R4 tx request", fifo_req, vexp);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule